// File: doc/BRIEF.md
# MII PAUSE Frame Receiver

This block sits on a 4-bit MII receive path and runs on the receive clock. It waits for a run of preamble nibbles closed by a start-of-frame nibble. It then pairs the nibbles that follow into bytes and passes every byte on as a one-cycle strobe. When data-valid falls it marks the end of the frame.

While the bytes stream past, the block compares the MAC control header with the fixed flow-control values. These are the reserved multicast destination, the control type and the PAUSE opcode. It also captures the 16-bit pause quantum that follows the opcode. If every checked field matched and the frame was long enough, a pause strobe follows the frame-end strobe, and the captured quantum is published on a held output. Ordinary traffic still passes through the byte stream unchanged. No flow-control event comes from it.

Top module: `mii_pause_rx`

## Requirements
- R1: While reset is low at a clock edge, `byte_vld`, `frame_end` and `pause_vld` are 0 after that edge and `pause_time` is 0.
- R2: A frame begins only when at least one 0x5 nibble is followed by a 0xD nibble, with data-valid high throughout. The first nibble after 0xD is the low half of byte 0. A 0xD with no preamble before it starts no frame.
- R3: Bytes are built low nibble first. `byte_vld` is high for one cycle, and `byte_data` holds {high, low}, in the cycle after the edge that samples the high nibble.
- R4: The first edge that samples data-valid low after a start-of-frame makes `frame_end` high for the next cycle. A lone trailing nibble produces no byte.
- R5: If data-valid falls before the start-of-frame nibble, or a nibble other than 0x5 or 0xD appears in the preamble, the frame is discarded. No byte and no `frame_end` is produced, and input is ignored until data-valid is low.
- R6: `pause_vld` is high for one cycle, in the cycle after `frame_end`, only when all three header fields match and at least 64 bytes were received. The fields are: bytes 0-5 equal 01 80 C2 00 00 01, bytes 12-13 equal 88 08, and bytes 14-15 equal 00 01.
- R7: When `pause_vld` is high, `pause_time` equals byte 16 × 256 + byte 17 of that frame. It holds its value in every other cycle.
- R8: Bytes 6-11 (source address) and bytes after 17 have no effect on `pause_vld` or `pause_time`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_nib | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data-valid |
| byte_vld | output | 1 | One-cycle strobe: `byte_data` carries a frame byte |
| byte_data | output | 8 | Assembled frame byte |
| frame_end | output | 1 | One-cycle strobe at the end of a framed packet |
| pause_vld | output | 1 | One-cycle strobe: a valid PAUSE frame was received |
| pause_time | output | 16 | Pause quantum of the last valid PAUSE frame |

## Verification
The bench sends a correct PAUSE frame at exactly 64 bytes, and then copies that differ in one field each: destination, type, opcode, and a 63-byte length. This shows whether each field check and the length threshold are enforced separately. A frame with a one-nibble preamble, a changed source address and a new quantum is also sent, along with a 100-byte frame carrying a zero quantum. These two confirm that fields which are not checked are ignored and that the published quantum tracks the latest good frame. Broken preambles, a dropped data-valid, a start-of-frame nibble with no preamble and a frame with an odd nibble count test framing alone, with no header decode involved.

// File: rtl/mpr_pkg.sv
// Shared constants and helpers for the MII PAUSE receiver.
// Assumes 4-bit MII nibbles and 8-bit bytes.
package mpr_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_PRE  = 2'd1,
        FR_DATA = 2'd2,
        FR_SKIP = 2'd3
    } fr_state_t;

    localparam logic [3:0] NIB_PRE = 4'h5;
    localparam logic [3:0] NIB_SFD = 4'hD;

    // Number of header byte positions that are compared.
    localparam int HDR_LEN   = 16;
    // Position of the first pause-quantum byte (most significant first).
    localparam int TIMER_IDX = 16;

    // Returns {check_enable, expected_byte} for a header byte position.
    function automatic logic [8:0] hdr_expect(input int idx);
        case (idx)
            0:       return {1'b1, 8'h01};
            1:       return {1'b1, 8'h80};
            2:       return {1'b1, 8'hC2};
            3:       return {1'b1, 8'h00};
            4:       return {1'b1, 8'h00};
            5:       return {1'b1, 8'h01};
            12:      return {1'b1, 8'h88};
            13:      return {1'b1, 8'h08};
            14:      return {1'b1, 8'h00};
            15:      return {1'b1, 8'h01};
            default: return {1'b0, 8'h00};
        endcase
    endfunction

endpackage

// File: rtl/mpr_framer.sv
// Nibble framer: finds preamble and start-of-frame, pairs nibbles into
// bytes (low nibble first) and marks the frame end.
// Assumes: inputs are synchronous to clk; any nibble other than the
// preamble value or the start-of-frame value inside the preamble aborts
// the frame until data-valid drops.
module mpr_framer
    import mpr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W/2-1:0] rx_nib,
    input  logic              rx_dv,
    output logic              sof,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_data,
    output logic              frame_end
);

    localparam int NIB_W = DATA_W / 2;

    fr_state_t          state;
    logic               phase_hi;
    logic [NIB_W-1:0]   low_nib;

    // Framing state machine and byte assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FR_IDLE;
            phase_hi  <= 1'b0;
            low_nib   <= '0;
            sof       <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            frame_end <= 1'b0;
        end else begin
            sof       <= 1'b0;
            byte_vld  <= 1'b0;
            frame_end <= 1'b0;
            case (state)
                FR_IDLE: begin
                    if (rx_dv) begin
                        state <= (rx_nib == NIB_W'(NIB_PRE)) ? FR_PRE : FR_SKIP;
                    end
                end
                FR_PRE: begin
                    if (!rx_dv) begin
                        state <= FR_IDLE;
                    end else if (rx_nib == NIB_W'(NIB_SFD)) begin
                        state    <= FR_DATA;
                        phase_hi <= 1'b0;
                        sof      <= 1'b1;
                    end else if (rx_nib != NIB_W'(NIB_PRE)) begin
                        state <= FR_SKIP;
                    end
                end
                FR_DATA: begin
                    if (!rx_dv) begin
                        frame_end <= 1'b1;
                        phase_hi  <= 1'b0;
                        state     <= FR_IDLE;
                    end else if (!phase_hi) begin
                        low_nib  <= rx_nib;
                        phase_hi <= 1'b1;
                    end else begin
                        byte_data <= {rx_nib, low_nib};
                        byte_vld  <= 1'b1;
                        phase_hi  <= 1'b0;
                    end
                end
                FR_SKIP: begin
                    if (!rx_dv) begin
                        state <= FR_IDLE;
                    end
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mpr_hdr_match.sv
// Control header matcher: counts frame bytes, compares the checked
// header positions against the flow-control constants, captures the
// pause quantum and raises a strobe after a qualifying frame ends.
// Assumes: sof precedes the first byte_vld of a frame; frame_end
// arrives after the last byte_vld of that frame.
module mpr_hdr_match
    import mpr_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 11,
    parameter int MIN_BYTES = 64,
    parameter int TIMER_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof,
    input  logic               byte_vld,
    input  logic [DATA_W-1:0]  byte_data,
    input  logic               frame_end,
    output logic               pause_vld,
    output logic [TIMER_W-1:0] pause_time
);

    localparam int TIMER_BYTES = TIMER_W / DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]   byte_cnt;
    logic               hdr_bad;
    logic [TIMER_W-1:0] timer_shadow;
    logic [HDR_LEN-1:0] miss;

    // One comparator per header position, enabled only at its byte index.
    for (genvar i = 0; i < HDR_LEN; i++) begin : g_cmp
        localparam logic [8:0] EXP = hdr_expect(i);
        if (EXP[8]) begin : g_on
            assign miss[i] = byte_vld && (byte_cnt == CNT_W'(i))
                             && (byte_data != EXP[DATA_W-1:0]);
        end else begin : g_off
            assign miss[i] = 1'b0;
        end
    end

    // Byte counting, mismatch tracking, quantum capture and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt     <= '0;
            hdr_bad      <= 1'b0;
            timer_shadow <= '0;
            pause_vld    <= 1'b0;
            pause_time   <= '0;
        end else begin
            pause_vld <= 1'b0;
            if (sof) begin
                byte_cnt <= '0;
                hdr_bad  <= 1'b0;
            end else if (byte_vld) begin
                if (byte_cnt != CNT_MAX) begin
                    byte_cnt <= byte_cnt + 1'b1;
                end
                if (|miss) begin
                    hdr_bad <= 1'b1;
                end
                for (int k = 0; k < TIMER_BYTES; k++) begin
                    if (byte_cnt == CNT_W'(TIMER_IDX + k)) begin
                        timer_shadow[TIMER_W-1-DATA_W*k -: DATA_W] <= byte_data;
                    end
                end
            end
            if (frame_end && !hdr_bad && (byte_cnt >= CNT_W'(MIN_BYTES))) begin
                pause_vld  <= 1'b1;
                pause_time <= timer_shadow;
            end
        end
    end

endmodule

// File: rtl/mii_pause_rx.sv
// MII PAUSE frame receiver top: framer followed by control header matcher.
// Assumes: a single receive clock domain and synchronous active-low reset.
module mii_pause_rx #(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 11,
    parameter int MIN_BYTES = 64,
    parameter int TIMER_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         rx_nib,
    input  logic               rx_dv,
    output logic               byte_vld,
    output logic [7:0]         byte_data,
    output logic               frame_end,
    output logic               pause_vld,
    output logic [15:0]        pause_time
);

    logic              sof_w;
    logic              bv_w;
    logic [DATA_W-1:0] bd_w;
    logic              fe_w;
    logic [TIMER_W-1:0] pt_w;

    mpr_framer #(.DATA_W(DATA_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_nib    (rx_nib),
        .rx_dv     (rx_dv),
        .sof       (sof_w),
        .byte_vld  (bv_w),
        .byte_data (bd_w),
        .frame_end (fe_w)
    );

    mpr_hdr_match #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .MIN_BYTES (MIN_BYTES),
        .TIMER_W   (TIMER_W)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof_w),
        .byte_vld   (bv_w),
        .byte_data  (bd_w),
        .frame_end  (fe_w),
        .pause_vld  (pause_vld),
        .pause_time (pt_w)
    );

    assign byte_vld   = bv_w;
    assign byte_data  = bd_w;
    assign frame_end  = fe_w;
    assign pause_time = pt_w;

endmodule

// File: rtl/mpr_checks.sv
// Protocol checker for mii_pause_rx, attached with bind.
module mpr_checks #(
    parameter int TIMER_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_dv,
    input logic               byte_vld,
    input logic               frame_end,
    input logic               pause_vld,
    input logic [TIMER_W-1:0] pause_time
);

    // R3: a byte strobe needs data-valid on the sampling edge before it.
    assert_byte_needs_dv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(rx_dv));

    // R4: frame end follows a sampled data-valid low and never joins a byte.
    assert_end_after_dv_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !$past(rx_dv));

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_vld, frame_end, pause_vld}));

    // R6: pause strobe comes only in the cycle after a frame end.
    assert_pause_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pause_vld |-> $past(frame_end));

    // R7: quantum output only changes alongside the pause strobe.
    assert_time_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_vld |-> $stable(pause_time));

endmodule

bind mii_pause_rx mpr_checks #(.TIMER_W(TIMER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_dv      (rx_dv),
    .byte_vld   (byte_vld),
    .frame_end  (frame_end),
    .pause_vld  (pause_vld),
    .pause_time (pause_time)
);

// File: tb/mii_pause_rx_test.sv
module mii_pause_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rx_nib = 4'h0;
    logic        rx_dv = 1'b0;
    logic        byte_vld;
    logic [7:0]  byte_data;
    logic        frame_end;
    logic        pause_vld;
    logic [15:0] pause_time;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    mii_pause_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_nib(rx_nib), .rx_dv(rx_dv),
        .byte_vld(byte_vld), .byte_data(byte_data), .frame_end(frame_end),
        .pause_vld(pause_vld), .pause_time(pause_time)
    );

    always #2 clk = ~clk;

    // Reference model state
    int         m_state = 0;
    bit         m_hi = 0;
    logic [3:0] m_low = 0;
    logic [7:0] m_q[$];
    bit         exp_bv = 0, exp_fe = 0, exp_pv = 0, pend = 0;
    logic [7:0] exp_bd = 0;
    logic [15:0] exp_pt = 0, pend_t = 0;
    logic [7:0] hdr_da[6] = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};

    function automatic bit hdr_ok();
        if (m_q.size() < 64) return 0;
        foreach (hdr_da[i]) if (m_q[i] != hdr_da[i]) return 0;
        if (m_q[12] != 8'h88 || m_q[13] != 8'h08) return 0;
        if (m_q[14] != 8'h00 || m_q[15] != 8'h01) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_hi = 0; exp_bv = 0; exp_fe = 0;
            exp_pv = 0; pend = 0; exp_pt = 0;
        end else begin
            exp_bv = 0; exp_fe = 0;
            exp_pv = pend; pend = 0;
            if (exp_pv) exp_pt = pend_t;
            case (m_state)
                0: if (rx_dv) m_state = (rx_nib == 4'h5) ? 1 : 3;
                1: if (!rx_dv) m_state = 0;
                   else if (rx_nib == 4'hD) begin m_state = 2; m_hi = 0; m_q.delete(); end
                   else if (rx_nib != 4'h5) m_state = 3;
                2: if (!rx_dv) begin
                       exp_fe = 1; m_state = 0;
                       pend = hdr_ok();
                       if (pend) pend_t = {m_q[16], m_q[17]};
                   end else if (!m_hi) begin m_low = rx_nib; m_hi = 1; end
                   else begin
                       exp_bd = {rx_nib, m_low}; exp_bv = 1; m_hi = 0;
                       m_q.push_back(exp_bd);
                   end
                default: if (!rx_dv) m_state = 0;
            endcase
        end
    end

    int obs_bytes = 0, obs_end = 0, obs_pause = 0;

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            bit bad;
            bad = 0;
            vectors++;
            if (byte_vld !== exp_bv || (exp_bv && byte_data !== exp_bd)) begin
                $display("FAIL R3 byte: actual vld=%0b data=%h expected vld=%0b data=%h",
                         byte_vld, byte_data, exp_bv, exp_bd);
                bad = 1;
            end
            if (frame_end !== exp_fe) begin
                $display("FAIL R4 frame_end: actual %0b expected %0b", frame_end, exp_fe);
                bad = 1;
            end
            if (pause_vld !== exp_pv) begin
                $display("FAIL R6 pause_vld: actual %0b expected %0b", pause_vld, exp_pv);
                bad = 1;
            end
            if (pause_time !== exp_pt) begin
                $display("FAIL R7 pause_time: actual %h expected %h", pause_time, exp_pt);
                bad = 1;
            end
            if (bad) miscompares++;
            if (byte_vld) obs_bytes++;
            if (frame_end) obs_end++;
            if (pause_vld) obs_pause++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic nib(input logic [3:0] n);
        rx_dv = 1'b1; rx_nib = n;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int k);
        rx_dv = 1'b0; rx_nib = 4'h0;
        repeat (k) begin @(posedge clk); #1; end
    endtask

    task automatic clear_obs();
        obs_bytes = 0; obs_end = 0; obs_pause = 0;
    endtask

    logic [7:0] fq[$];

    task automatic build(input logic [15:0] timer, input logic [7:0] src, input int len);
        fq.delete();
        foreach (hdr_da[i]) fq.push_back(hdr_da[i]);
        for (int i = 0; i < 6; i++) fq.push_back(src + 8'(i));
        fq.push_back(8'h88); fq.push_back(8'h08);
        fq.push_back(8'h00); fq.push_back(8'h01);
        fq.push_back(timer[15:8]); fq.push_back(timer[7:0]);
        while (fq.size() < len) fq.push_back(8'h00);
    endtask

    task automatic send(input int pre, input bit odd);
        clear_obs();
        for (int i = 0; i < pre; i++) nib(4'h5);
        nib(4'hD);
        foreach (fq[i]) begin nib(fq[i][3:0]); nib(fq[i][7:4]); end
        if (odd) nib(4'h9);
        idle(6);
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog: actual timeout expected completion");
        miscompares++;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 byte_vld", byte_vld, 0);
        chk("R1 frame_end", frame_end, 0);
        chk("R1 pause_vld", pause_vld, 0);
        chk("R1 pause_time", pause_time, 0);
        rst_n = 1'b1;
        idle(3);

        // Good PAUSE frame, exactly 64 bytes.
        build(16'h1234, 8'h10, 64); send(15, 0);
        chk("R3 bytes good", obs_bytes, 64);
        chk("R4 end good", obs_end, 1);
        chk("R6 pause good", obs_pause, 1);
        chk("R7 time good", pause_time, 16'h1234);

        // Wrong destination byte.
        build(16'h5555, 8'h10, 64); fq[5] = 8'h02; send(15, 0);
        chk("R6 bad dest", obs_pause, 0);
        chk("R7 hold after bad dest", pause_time, 16'h1234);

        // Wrong type.
        build(16'h5555, 8'h10, 64); fq[13] = 8'h09; send(15, 0);
        chk("R6 bad type", obs_pause, 0);
        chk("R3 bytes bad type", obs_bytes, 64);

        // Wrong opcode.
        build(16'h5555, 8'h10, 64); fq[15] = 8'h02; send(7, 0);
        chk("R6 bad opcode", obs_pause, 0);

        // One byte short.
        build(16'h5555, 8'h10, 63); send(15, 0);
        chk("R6 short frame", obs_pause, 0);
        chk("R4 end short", obs_end, 1);

        // Short preamble, other source address, new quantum.
        build(16'hABCD, 8'hE7, 64); send(1, 0);
        chk("R2 one-nibble preamble", obs_bytes, 64);
        chk("R8 source ignored", obs_pause, 1);
        chk("R7 time second", pause_time, 16'hABCD);

        // Long frame with nonzero tail and zero quantum.
        build(16'h0000, 8'h33, 100); fq[70] = 8'hFF; send(15, 0);
        chk("R8 long tail", obs_pause, 1);
        chk("R7 zero quantum", pause_time, 0);

        // Bad nibble inside preamble.
        build(16'h7777, 8'h10, 64); clear_obs();
        nib(4'h5); nib(4'h5); nib(4'h7); nib(4'h5); nib(4'hD);
        foreach (fq[i]) begin nib(fq[i][3:0]); nib(fq[i][7:4]); end
        idle(6);
        chk("R5 bad preamble bytes", obs_bytes, 0);
        chk("R5 bad preamble end", obs_end, 0);
        chk("R5 bad preamble pause", obs_pause, 0);

        // Data-valid drops before start-of-frame.
        clear_obs();
        nib(4'h5); nib(4'h5); nib(4'h5); idle(2);
        nib(4'h3); nib(4'h4); idle(4);
        chk("R5 dv drop end", obs_end, 0);
        chk("R5 dv drop bytes", obs_bytes, 0);

        // Start-of-frame without preamble.
        build(16'h7777, 8'h10, 64); clear_obs();
        nib(4'hD);
        foreach (fq[i]) begin nib(fq[i][3:0]); nib(fq[i][7:4]); end
        idle(6);
        chk("R2 no preamble bytes", obs_bytes, 0);
        chk("R7 time after junk", pause_time, 0);

        // Odd trailing nibble.
        fq.delete();
        for (int i = 0; i < 10; i++) fq.push_back(8'(8'h21 * i));
        send(15, 1);
        chk("R4 odd bytes", obs_bytes, 10);
        chk("R4 odd end", obs_end, 1);

        idle(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule